// File: doc/BRIEF.md
# Two-Way Hashed MAC Address Table

This block keeps the station table of a small layer-2 switch. Every entry pairs a 48-bit MAC address with the switch port it was last seen on. The entries sit in a two-way set-associative store, and a hash of the address selects the set. One request port looks up a destination address and returns hit and port. A second port learns a source address after a good unicast frame has been fully received. A third port preloads static entries, which never expire.

A background sweep removes stale dynamic entries. A timer raises an aging tick once every `AGE_UNIT * cfg_max_age` clock cycles. Each tick starts one pass over all sets. The pass evicts every dynamic entry already marked old and marks all other dynamic entries. Any hit by a lookup or a learn clears the mark, so stations that stay active are kept. With the default `AGE_UNIT` of 64M cycles, the 9-bit age value gives the usual aging time of a few hundred seconds at a 90 MHz kernel clock.

The table has a single memory access per cycle. It serves the requesters in this fixed order: lookup, then static configuration, then learning, then the sweep.

Top module: `mac_addr_table`

## Requirements
- R1: After reset the table is empty: `lk_valid` is low and every lookup misses with port 0.
- R2: A lookup request sampled at a clock edge yields `lk_valid` high at that edge, with `lk_hit` and `lk_port` for the address. It yields `lk_valid` low when no request was sampled.
- R3: With `cfg_hash_linear`=1, the set index is the low `IDX_W` bits of the address. With 0, it is the XOR of all consecutive `IDX_W`-bit slices of the address starting at bit 0, with the top slice zero-padded.
- R4: A learn request is acknowledged but changes nothing when `ln_good` is low or when address bit 40 is 1, which marks a group address.
- R5: A learn that hits a dynamic entry updates its port. A learn that hits a static entry leaves that entry unchanged.
- R6: A configuration request installs a static entry with the given port, or overwrites the entry for the same address. Learning never replaces a static entry. When both ways of a set are static, a learn miss and a configuration miss are both discarded.
- R7: On a miss, the new entry goes to the first free way, way 0 before way 1. If no way is free, it replaces a marked dynamic way before an unmarked one, way 0 first.
- R8: A lookup request takes the access: `st_ack` and `ln_ack` stay low in any cycle with `lk_req` high.
- R9: A configuration request is served before a learn request: `ln_ack` stays low while `st_req` is high.
- R10: With aging enabled, a dynamic entry that sees no hit across two aging ticks is evicted. Static entries are never evicted.
- R11: A lookup hit clears the entry's age mark, so an entry looked up between every pair of ticks survives.
- R12: The aging tick period is `AGE_UNIT * cfg_max_age` cycles. No ticks occur while `cfg_age_en` is 0 or `cfg_max_age` is 0.
- R13: The sweep advances only in cycles with no lookup, configuration or learn request. Under a continuous stream of lookups, no entry is aged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hash_linear | input | 1 | 1 = linear index hash, 0 = XOR-fold hash |
| cfg_age_en | input | 1 | Enables the aging timer and sweep |
| cfg_max_age | input | 9 | Aging period in units of `AGE_UNIT` cycles |
| lk_req | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination address to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Address found |
| lk_port | output | 3 | Port of the found entry, 0 on a miss |
| ln_req | input | 1 | Learn request, held until acknowledged |
| ln_good | input | 1 | Frame was good and complete |
| ln_mac | input | 48 | Source address to learn |
| ln_port | input | 3 | Receive port of the frame |
| ln_ack | output | 1 | Learn request served this cycle |
| st_req | input | 1 | Static entry request, held until acknowledged |
| st_mac | input | 48 | Static address |
| st_port | input | 3 | Static port |
| st_ack | output | 1 | Static request served this cycle |

## Verification
The bench fills a single set through colliding addresses. This exposes a replacement policy that evicts a static way, or one that ignores the age mark. Either fault shows up as the wrong survivor on the next lookup. The same three addresses run under both hash modes: a swapped hash select would collide them in XOR mode, or spread them in linear mode.

Aging is tested against timing windows. An entry must survive one tick and be gone after two. It must survive indefinitely when refreshed by lookups or when the sweep is starved. A timer off by a factor, or a sweep that ran during busy cycles, would evict an entry that should remain.

Simultaneous requests confirm the service order. A wrong order would acknowledge a blocked requester.

// File: rtl/mat_pkg.sv
package mat_pkg;
  parameter int unsigned MAC_W  = 48;
  parameter int unsigned PORT_W = 3;
  parameter int unsigned AGE_W  = 9;
  localparam int unsigned WAYS      = 2;
  localparam int unsigned GROUP_BIT = 40;

  typedef struct packed {
    logic              vld;
    logic              stat;
    logic              aged;
    logic [PORT_W-1:0] port;
    logic [MAC_W-1:0]  mac;
  } ent_t;

  localparam int unsigned ENT_W = $bits(ent_t);
endpackage

// File: rtl/mat_hash.sv
module mat_hash
  import mat_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [MAC_W-1:0] mac,
  input  logic             linear,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned NSLICE = (MAC_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NSLICE * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] folded;

  assign padded = PAD_W'(mac);

  always_comb begin
    folded = '0;
    for (int s = 0; s < NSLICE; s++) begin
      folded = folded ^ padded[s*IDX_W +: IDX_W];
    end
  end

  assign idx = linear ? mac[IDX_W-1:0] : folded;
endmodule

// File: rtl/mat_store.sv
module mat_store
  import mat_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  output ent_t [WAYS-1:0]       rd_ent,
  input  logic [WAYS-1:0]       wr_en,
  input  ent_t [WAYS-1:0]       wr_ent
);
  localparam int unsigned SETS = 1 << IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [ENT_W-2:0] body_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (wr_en[w]) begin
        vld_q[idx] <= wr_ent[w].vld;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en[w]) begin
        body_q[idx] <= wr_ent[w][ENT_W-2:0];
      end
    end

    assign rd_ent[w] = {vld_q[idx], body_q[idx]};
  end
endmodule

// File: rtl/mat_age_timer.sv
module mat_age_timer
  import mat_pkg::*;
#(
  parameter int unsigned AGE_UNIT = 64 * 1024 * 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AGE_W-1:0] max_age,
  output logic             tick
);
  localparam int unsigned PRE_W = (AGE_UNIT > 2) ? $clog2(AGE_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(AGE_UNIT - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [AGE_W-1:0] unit_q, unit_d;
  logic             run, unit_end;

  always_comb begin
    run      = en && (max_age != '0);
    unit_end = run && (pre_q == PRE_LAST);
    tick     = unit_end && (unit_q >= max_age - AGE_W'(1));
    pre_d    = pre_q;
    unit_d   = unit_q;
    if (!run) begin
      pre_d  = '0;
      unit_d = '0;
    end else if (unit_end) begin
      pre_d  = '0;
      unit_d = tick ? '0 : unit_q + AGE_W'(1);
    end else begin
      pre_d  = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (en && max_age != '0));
endmodule

// File: rtl/mac_addr_table.sv
module mac_addr_table
  import mat_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned AGE_UNIT = 64 * 1024 * 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hash_linear,
  input  logic              cfg_age_en,
  input  logic [AGE_W-1:0]  cfg_max_age,
  input  logic              lk_req,
  input  logic [MAC_W-1:0]  lk_mac,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic [PORT_W-1:0] lk_port,
  input  logic              ln_req,
  input  logic              ln_good,
  input  logic [MAC_W-1:0]  ln_mac,
  input  logic [PORT_W-1:0] ln_port,
  output logic              ln_ack,
  input  logic              st_req,
  input  logic [MAC_W-1:0]  st_mac,
  input  logic [PORT_W-1:0] st_port,
  output logic              st_ack
);
  localparam logic [IDX_W-1:0] LAST_SET = '1;

  logic              rst_meta_q, run_q;
  logic              op_lk, op_st, op_ln, op_sw;
  logic [MAC_W-1:0]  key;
  logic [IDX_W-1:0]  hash_idx, rd_idx;
  ent_t [WAYS-1:0]   rd_ent, wr_ent;
  logic [WAYS-1:0]   wr_en, match, stat_v, dyn_v, aged_v;
  logic              hit, hit_way, vic_ok, vic_way, tick;
  ent_t              new_ent;
  logic              sweep_q, sweep_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic              lk_valid_d, lk_hit_d;
  logic [PORT_W-1:0] lk_port_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      run_q      <= rst_meta_q;
    end
  end

  // access arbitration: lookup, static config, learn, sweep
  always_comb begin
    op_lk  = run_q && lk_req;
    op_st  = run_q && st_req && !lk_req;
    op_ln  = run_q && ln_req && !lk_req && !st_req;
    op_sw  = run_q && sweep_q && !lk_req && !st_req && !ln_req;
    st_ack = op_st;
    ln_ack = op_ln;
    key    = lk_req ? lk_mac : (st_req ? st_mac : ln_mac);
    rd_idx = op_sw ? ptr_q : hash_idx;
  end

  mat_hash #(.IDX_W(IDX_W)) u_hash (
    .mac    (key),
    .linear (cfg_hash_linear),
    .idx    (hash_idx)
  );

  mat_store #(.IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (rd_idx),
    .rd_ent (rd_ent),
    .wr_en  (wr_en),
    .wr_ent (wr_ent)
  );

  mat_age_timer #(.AGE_UNIT(AGE_UNIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_age_en),
    .max_age (cfg_max_age),
    .tick    (tick)
  );

  // compare and victim choice
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match[w]  = rd_ent[w].vld && (rd_ent[w].mac == key);
      stat_v[w] = rd_ent[w].vld && rd_ent[w].stat;
      dyn_v[w]  = rd_ent[w].vld && !rd_ent[w].stat;
      aged_v[w] = dyn_v[w] && rd_ent[w].aged;
    end
    hit     = |match;
    hit_way = !match[0];
    vic_ok  = 1'b1;
    if (!rd_ent[0].vld)      vic_way = 1'b0;
    else if (!rd_ent[1].vld) vic_way = 1'b1;
    else if (aged_v[0])      vic_way = 1'b0;
    else if (aged_v[1])      vic_way = 1'b1;
    else if (dyn_v[0])       vic_way = 1'b0;
    else if (dyn_v[1])       vic_way = 1'b1;
    else begin
      vic_way = 1'b0;
      vic_ok  = 1'b0;
    end
  end

  // write-back
  always_comb begin
    wr_en   = '0;
    wr_ent  = rd_ent;
    new_ent = '{vld: 1'b1, stat: op_st, aged: 1'b0,
                port: (op_st ? st_port : ln_port), mac: key};
    if (op_lk) begin
      if (hit) begin
        wr_en[hit_way]       = 1'b1;
        wr_ent[hit_way].aged = 1'b0;
      end
    end else if (op_st) begin
      if (hit) begin
        wr_en[hit_way]  = 1'b1;
        wr_ent[hit_way] = new_ent;
      end else if (vic_ok) begin
        wr_en[vic_way]  = 1'b1;
        wr_ent[vic_way] = new_ent;
      end
    end else if (op_ln && ln_good && !key[GROUP_BIT]) begin
      if (hit) begin
        if (!rd_ent[hit_way].stat) begin
          wr_en[hit_way]  = 1'b1;
          wr_ent[hit_way] = new_ent;
        end
      end else if (vic_ok) begin
        wr_en[vic_way]  = 1'b1;
        wr_ent[vic_way] = new_ent;
      end
    end else if (op_sw) begin
      for (int w = 0; w < WAYS; w++) begin
        if (dyn_v[w]) begin
          wr_en[w] = 1'b1;
          if (rd_ent[w].aged) wr_ent[w].vld  = 1'b0;
          else                wr_ent[w].aged = 1'b1;
        end
      end
    end
  end

  // sweep and result next state
  always_comb begin
    sweep_d = sweep_q;
    ptr_d   = ptr_q;
    if (!cfg_age_en) begin
      sweep_d = 1'b0;
    end else if (!sweep_q) begin
      if (tick) begin
        sweep_d = 1'b1;
        ptr_d   = '0;
      end
    end else if (op_sw) begin
      ptr_d = ptr_q + IDX_W'(1);
      if (ptr_q == LAST_SET) sweep_d = 1'b0;
    end
    lk_valid_d = op_lk;
    lk_hit_d   = op_lk && hit;
    lk_port_d  = (op_lk && hit) ? rd_ent[hit_way].port : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q  <= 1'b0;
      ptr_q    <= '0;
      lk_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_port  <= '0;
    end else begin
      sweep_q  <= sweep_d;
      ptr_q    <= ptr_d;
      lk_valid <= lk_valid_d;
      lk_hit   <= lk_hit_d;
      lk_port  <= lk_port_d;
    end
  end

  // R2
  lk_resp_chk: assert property (@(posedge clk) disable iff (!run_q)
    lk_req |=> lk_valid);
  // R2
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);
  // R8
  lk_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (!st_ack && !ln_ack));
  // R9
  cfg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> !ln_ack);
  // R13
  sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_q && (lk_req || st_req || ln_req)) |=> $stable(ptr_q));
  // R6
  static_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ln && |wr_en) |-> ((wr_en & stat_v) == '0));
endmodule

// File: tb/sim_mac_addr_table.sv
module sim_mac_addr_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_hash_linear, cfg_age_en;
  logic [8:0]  cfg_max_age;
  logic        lk_req, lk_valid, lk_hit;
  logic [47:0] lk_mac;
  logic [2:0]  lk_port;
  logic        ln_req, ln_good, ln_ack;
  logic [47:0] ln_mac;
  logic [2:0]  ln_port;
  logic        st_req, st_ack;
  logic [47:0] st_mac;
  logic [2:0]  st_port;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mac_addr_table #(.IDX_W(4), .AGE_UNIT(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_hash_linear(cfg_hash_linear), .cfg_age_en(cfg_age_en), .cfg_max_age(cfg_max_age),
    .lk_req(lk_req), .lk_mac(lk_mac), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_port(lk_port),
    .ln_req(ln_req), .ln_good(ln_good), .ln_mac(ln_mac), .ln_port(ln_port), .ln_ack(ln_ack),
    .st_req(st_req), .st_mac(st_mac), .st_port(st_port), .st_ack(st_ack)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_hash_linear = 1'b0; cfg_age_en = 1'b0; cfg_max_age = '0;
    lk_req = 1'b0; lk_mac = '0;
    ln_req = 1'b0; ln_good = 1'b0; ln_mac = '0; ln_port = '0;
    st_req = 1'b0; st_mac = '0; st_port = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic lookup(input logic [47:0] m, output logic h, output logic [2:0] p);
    @(negedge clk);
    lk_req = 1'b1; lk_mac = m;
    @(posedge clk); #1;
    h = lk_hit; p = lk_port;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic expect_lk(input logic [47:0] m, input logic eh, input logic [2:0] ep,
                           input string req);
    logic h; logic [2:0] p;
    lookup(m, h, p);
    check(h == eh, req, "hit", 64'(h), 64'(eh));
    if (eh) check(p == ep, req, "port", 64'(p), 64'(ep));
  endtask

  task automatic learn(input logic [47:0] m, input logic [2:0] p, input logic g);
    @(negedge clk);
    ln_req = 1'b1; ln_mac = m; ln_port = p; ln_good = g;
    #1;
    while (!ln_ack) begin @(negedge clk); #1; end
    @(negedge clk);
    ln_req = 1'b0;
  endtask

  task automatic config_st(input logic [47:0] m, input logic [2:0] p);
    @(negedge clk);
    st_req = 1'b1; st_mac = m; st_port = p;
    #1;
    while (!st_ack) begin @(negedge clk); #1; end
    @(negedge clk);
    st_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(lk_valid == 1'b0, "R1", "lk_valid after reset", 64'(lk_valid), 0);
    expect_lk(48'h0000_0000_0001, 1'b0, 3'd0, "R1");
  endtask

  task automatic t_basic();
    logic h; logic [2:0] p;
    do_reset();
    learn(48'h0012_3456_789A, 3'd5, 1'b1);
    @(negedge clk);
    lk_req = 1'b1; lk_mac = 48'h0012_3456_789A;
    @(posedge clk); #1;
    check(lk_valid == 1'b1, "R2", "lk_valid on request", 64'(lk_valid), 1);
    check(lk_hit == 1'b1 && lk_port == 3'd5, "R2", "hit/port", {lk_hit, lk_port}, {1'b1, 3'd5});
    @(negedge clk);
    lk_req = 1'b0;
    @(posedge clk); #1;
    check(lk_valid == 1'b0, "R2", "lk_valid idle", 64'(lk_valid), 0);
    lookup(48'h0012_3456_7890, h, p);
    check(h == 1'b0 && p == 3'd0, "R2", "unknown miss", {h, p}, 0);
  endtask

  task automatic t_filter();
    do_reset();
    learn(48'h0000_0000_0A07, 3'd1, 1'b0);
    expect_lk(48'h0000_0000_0A07, 1'b0, 3'd0, "R4");
    learn(48'h0100_0000_0B07, 3'd2, 1'b1);
    expect_lk(48'h0100_0000_0B07, 1'b0, 3'd0, "R4");
    learn(48'h0000_0000_0C07, 3'd3, 1'b1);
    expect_lk(48'h0000_0000_0C07, 1'b1, 3'd3, "R4");
  endtask

  task automatic t_move();
    do_reset();
    learn(48'h0000_0000_0102, 3'd2, 1'b1);
    learn(48'h0000_0000_0102, 3'd6, 1'b1);
    expect_lk(48'h0000_0000_0102, 1'b1, 3'd6, "R5");
    config_st(48'h0000_0000_0203, 3'd1);
    learn(48'h0000_0000_0203, 3'd4, 1'b1);
    expect_lk(48'h0000_0000_0203, 1'b1, 3'd1, "R5");
  endtask

  task automatic t_hash();
    do_reset();
    cfg_hash_linear = 1'b1;
    learn(48'h0000_0000_0001, 3'd1, 1'b1);
    learn(48'h0000_0001_0001, 3'd2, 1'b1);
    learn(48'h0000_0002_0001, 3'd3, 1'b1);
    expect_lk(48'h0000_0000_0001, 1'b0, 3'd0, "R3");
    expect_lk(48'h0000_0001_0001, 1'b1, 3'd2, "R7");
    expect_lk(48'h0000_0002_0001, 1'b1, 3'd3, "R3");
    do_reset();
    cfg_hash_linear = 1'b0;
    learn(48'h0000_0000_0001, 3'd1, 1'b1);
    learn(48'h0000_0001_0001, 3'd2, 1'b1);
    learn(48'h0000_0002_0001, 3'd3, 1'b1);
    expect_lk(48'h0000_0000_0001, 1'b1, 3'd1, "R3");
    expect_lk(48'h0000_0001_0001, 1'b1, 3'd2, "R3");
    expect_lk(48'h0000_0002_0001, 1'b1, 3'd3, "R3");
  endtask

  task automatic t_aged_victim();
    logic h; logic [2:0] p;
    do_reset();
    cfg_hash_linear = 1'b1;
    learn(48'h0000_0000_0001, 3'd1, 1'b1);
    learn(48'h0000_0000_0011, 3'd2, 1'b1);
    cfg_max_age = 9'd10; cfg_age_en = 1'b1;
    idle(60);
    lookup(48'h0000_0000_0001, h, p);
    cfg_age_en = 1'b0;
    learn(48'h0000_0000_0021, 3'd3, 1'b1);
    expect_lk(48'h0000_0000_0001, 1'b1, 3'd1, "R7");
    expect_lk(48'h0000_0000_0011, 1'b0, 3'd0, "R7");
    expect_lk(48'h0000_0000_0021, 1'b1, 3'd3, "R7");
  endtask

  task automatic t_static();
    do_reset();
    cfg_hash_linear = 1'b1;
    config_st(48'h0000_0000_1005, 3'd1);
    config_st(48'h0000_0000_2005, 3'd2);
    learn(48'h0000_0000_3005, 3'd3, 1'b1);
    config_st(48'h0000_0000_4005, 3'd4);
    expect_lk(48'h0000_0000_3005, 1'b0, 3'd0, "R6");
    expect_lk(48'h0000_0000_4005, 1'b0, 3'd0, "R6");
    expect_lk(48'h0000_0000_1005, 1'b1, 3'd1, "R6");
    expect_lk(48'h0000_0000_2005, 1'b1, 3'd2, "R6");
    config_st(48'h0000_0000_2005, 3'd7);
    expect_lk(48'h0000_0000_2005, 1'b1, 3'd7, "R6");
  endtask

  task automatic t_prio();
    do_reset();
    @(negedge clk);
    lk_req = 1'b1; lk_mac = 48'h0000_0000_000A;
    st_req = 1'b1; st_mac = 48'h0000_0000_000B; st_port = 3'd3;
    ln_req = 1'b1; ln_mac = 48'h0000_0000_000C; ln_port = 3'd4; ln_good = 1'b1;
    #1;
    check(st_ack == 1'b0, "R8", "st_ack under lookup", 64'(st_ack), 0);
    check(ln_ack == 1'b0, "R8", "ln_ack under lookup", 64'(ln_ack), 0);
    @(negedge clk);
    lk_req = 1'b0;
    #1;
    check(st_ack == 1'b1, "R9", "st_ack served", 64'(st_ack), 1);
    check(ln_ack == 1'b0, "R9", "ln_ack waits", 64'(ln_ack), 0);
    @(negedge clk);
    st_req = 1'b0;
    #1;
    check(ln_ack == 1'b1, "R9", "ln_ack served", 64'(ln_ack), 1);
    @(negedge clk);
    ln_req = 1'b0;
    expect_lk(48'h0000_0000_000B, 1'b1, 3'd3, "R9");
    expect_lk(48'h0000_0000_000C, 1'b1, 3'd4, "R9");
  endtask

  task automatic t_age();
    do_reset();
    learn(48'h0000_0000_0304, 3'd2, 1'b1);
    config_st(48'h0000_0000_0405, 3'd6);
    cfg_max_age = 9'd20; cfg_age_en = 1'b1;
    idle(110);
    expect_lk(48'h0000_0000_0304, 1'b1, 3'd2, "R12");
    do_reset();
    learn(48'h0000_0000_0304, 3'd2, 1'b1);
    config_st(48'h0000_0000_0405, 3'd6);
    cfg_max_age = 9'd10; cfg_age_en = 1'b1;
    idle(110);
    expect_lk(48'h0000_0000_0304, 1'b0, 3'd0, "R10");
    expect_lk(48'h0000_0000_0405, 1'b1, 3'd6, "R10");
  endtask

  task automatic t_refresh();
    do_reset();
    learn(48'h0000_0000_0506, 3'd5, 1'b1);
    cfg_max_age = 9'd10; cfg_age_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      idle(18);
      expect_lk(48'h0000_0000_0506, 1'b1, 3'd5, "R11");
    end
  endtask

  task automatic t_off();
    do_reset();
    learn(48'h0000_0000_0607, 3'd1, 1'b1);
    cfg_max_age = 9'd10; cfg_age_en = 1'b0;
    idle(200);
    expect_lk(48'h0000_0000_0607, 1'b1, 3'd1, "R12");
    cfg_max_age = 9'd0; cfg_age_en = 1'b1;
    idle(200);
    expect_lk(48'h0000_0000_0607, 1'b1, 3'd1, "R12");
  endtask

  task automatic t_starve();
    do_reset();
    learn(48'h0000_0000_0708, 3'd2, 1'b1);
    cfg_max_age = 9'd10; cfg_age_en = 1'b1;
    @(negedge clk);
    lk_req = 1'b1; lk_mac = 48'h0000_0000_0F0F;
    idle(200);
    lk_mac = 48'h0000_0000_0708;
    @(posedge clk); #1;
    check(lk_hit == 1'b1 && lk_port == 3'd2, "R13", "starved sweep keeps entry",
          {lk_hit, lk_port}, {1'b1, 3'd2});
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_filter();
    t_move();
    t_hash();
    t_aged_victim();
    t_static();
    t_prio();
    t_age();
    t_refresh();
    t_off();
    t_starve();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule